// File: doc/BRIEF.md
# Dual-Rail Early-Output AND Stage

This block is one pipeline stage that forms the bitwise AND of two operand vectors carried in dual-rail code. Every logical bit travels on a pair of wires: a "one" rail and a "zero" rail. Each of the two operand channels and the result channel runs its own four-phase return-to-zero handshake. A sender drives valid codes and waits for the acknowledge to rise. It then returns its rails to NULL and waits for the acknowledge to fall.

The stage works on an early-output principle. A result bit is decided as soon as the arrived inputs settle it. A zero on either operand bit forces a zero result, even while the other operand bit is still NULL. A one on the result needs ones on both operands. The stage does not wait for the slower operand. It tracks completion separately for each input channel and acknowledges each channel only once that channel's whole vector has arrived. It lets its result fall back to NULL only after both channels have been absorbed and have gone empty. A late operand therefore can never be mistaken for the next data phase. Rails and acknowledges are registered on a free-running sampling clock, so every reaction shows up one clock edge after its cause.

Top module: `dr_and_stage`

## Requirements
- R1: Each bit uses the rail pair (one, zero). The code (0,0) is NULL, (0,1) is logic zero and (1,0) is logic one. The code (1,1) must never appear on any input or on the output.
- R2: While `rst_n` is low, every result rail and both input acknowledges are low.
- R3: While `y_ack` is low, a NULL result bit becomes a valid zero one clock edge after either operand bit shows a zero, whatever the other operand bit holds.
- R4: A result bit becomes a valid one only when both operand bits were valid ones at the preceding edge. It stays NULL while only one operand is a one.
- R5: Once both operand vectors are valid, the result rails equal (a AND b) on the one rail and its complement on the zero rail, one edge later.
- R6: A valid result bit keeps its value until the whole result returns to NULL.
- R7: An input acknowledge rises one edge after `y_ack` is high and that channel's vector is complete. It stays low while any bit of that channel is NULL.
- R8: An input acknowledge falls one edge after its channel is all NULL with `y_ack` low. It stays high while that channel still carries data.
- R9: The result returns to NULL one edge after three things all hold: both input acknowledges are high, both channels are all NULL, and `y_ack` is high. A channel that has not been acknowledged holds the result valid.
- R10: While `y_ack` is high, no result bit changes from NULL to a valid code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running sampling clock |
| rst_n | input | 1 | Active-low reset, clears rails and acknowledges |
| a_r1 | input | W | Operand A, one rails |
| a_r0 | input | W | Operand A, zero rails |
| a_ack | output | 1 | Acknowledge for operand A |
| b_r1 | input | W | Operand B, one rails |
| b_r0 | input | W | Operand B, zero rails |
| b_ack | output | 1 | Acknowledge for operand B |
| y_r1 | output | W | Result, one rails |
| y_r0 | output | W | Result, zero rails |
| y_ack | input | 1 | Acknowledge from the downstream consumer |

## Verification
The bench builds the stage with the default width of eight bits. This is wide enough for one vector to mix zeros and ones, so early zeros and pending NULL bits can be seen side by side in a single result word. A table of operand pairs with varying arrival order and gaps drives complete handshakes. At each gap the bench checks that only the zero positions of the first operand have resolved. Directed cases then cover the reset state, a late operand arriving after its partner has already been released, and data offered while the downstream acknowledge is still high.

// File: rtl/dr_pkg.sv
package dr_pkg;

    // rail pair packed as {one_rail, zero_rail}
    typedef enum logic [1:0] {
        DR_NULL = 2'b00,
        DR_ZERO = 2'b01,
        DR_ONE  = 2'b10,
        DR_BAD  = 2'b11
    } dr_code_e;

    function automatic dr_code_e dr_code(input logic r1, input logic r0);
        return dr_code_e'({r1, r0});
    endfunction

endpackage

// File: rtl/dr_chan_status.sv
// Completion and emptiness detection for one dual-rail channel.
module dr_chan_status #(
    parameter int W = 8
) (
    input  logic [W-1:0] r1,
    input  logic [W-1:0] r0,
    output logic [W-1:0] bit_valid,
    output logic         full,
    output logic         empty
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bit_valid[i] = r1[i] | r0[i];
    end

    assign full  = &bit_valid;
    assign empty = ~|bit_valid;
endmodule

// File: rtl/dr_eo_and_cell.sv
// Next-state logic for one early-output AND result bit.
module dr_eo_and_cell
    import dr_pkg::*;
(
    input  logic a_r1,
    input  logic a_r0,
    input  logic b_r1,
    input  logic b_r0,
    input  logic q_r1,
    input  logic q_r0,
    input  logic fire_en,
    input  logic clr,
    output logic d_r1,
    output logic d_r0
);
    dr_code_e a_c, b_c, q_c;
    logic     any_zero, both_one;

    always_comb begin
        a_c      = dr_code(a_r1, a_r0);
        b_c      = dr_code(b_r1, b_r0);
        q_c      = dr_code(q_r1, q_r0);
        any_zero = (a_c == DR_ZERO) || (b_c == DR_ZERO);
        both_one = (a_c == DR_ONE) && (b_c == DR_ONE);
        d_r1     = q_r1;
        d_r0     = q_r0;
        if (clr) begin
            d_r1 = 1'b0;
            d_r0 = 1'b0;
        end else if (q_c == DR_NULL && fire_en) begin
            d_r0 = any_zero;
            d_r1 = both_one;
        end
    end
endmodule

// File: rtl/dr_ack_celem.sv
// Set/reset hold element standing in for a C-element on an acknowledge.
module dr_ack_celem (
    input  logic set_c,
    input  logic rst_c,
    input  logic q,
    output logic d
);
    always_comb begin
        if (set_c)      d = 1'b1;
        else if (rst_c) d = 1'b0;
        else            d = q;
    end
endmodule

// File: rtl/dr_and_stage.sv
module dr_and_stage
    import dr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_r1,
    input  logic [W-1:0] a_r0,
    output logic         a_ack,
    input  logic [W-1:0] b_r1,
    input  logic [W-1:0] b_r0,
    output logic         b_ack,
    output logic [W-1:0] y_r1,
    output logic [W-1:0] y_r0,
    input  logic         y_ack
);
    typedef struct packed {
        logic [W-1:0] y1;
        logic [W-1:0] y0;
        logic         ack_a;
        logic         ack_b;
    } stage_t;

    stage_t st_d, st_q;

    logic [W-1:0] a_valid, b_valid;
    logic         a_full, a_empty, b_full, b_empty;
    logic [W-1:0] cell_r1, cell_r0;
    logic         drain, fire_en;
    logic         ack_a_nx, ack_b_nx;

    dr_chan_status #(.W(W)) u_a_stat (
        .r1(a_r1), .r0(a_r0), .bit_valid(a_valid), .full(a_full), .empty(a_empty)
    );
    dr_chan_status #(.W(W)) u_b_stat (
        .r1(b_r1), .r0(b_r0), .bit_valid(b_valid), .full(b_full), .empty(b_empty)
    );

    assign drain   = st_q.ack_a & st_q.ack_b & a_empty & b_empty & y_ack;
    assign fire_en = ~y_ack;

    for (genvar i = 0; i < W; i++) begin : g_cell
        dr_eo_and_cell u_cell (
            .a_r1(a_r1[i]), .a_r0(a_r0[i]),
            .b_r1(b_r1[i]), .b_r0(b_r0[i]),
            .q_r1(st_q.y1[i]), .q_r0(st_q.y0[i]),
            .fire_en(fire_en), .clr(drain),
            .d_r1(cell_r1[i]), .d_r0(cell_r0[i])
        );
    end

    dr_ack_celem u_ack_a (
        .set_c(y_ack & a_full), .rst_c(~y_ack & a_empty), .q(st_q.ack_a), .d(ack_a_nx)
    );
    dr_ack_celem u_ack_b (
        .set_c(y_ack & b_full), .rst_c(~y_ack & b_empty), .q(st_q.ack_b), .d(ack_b_nx)
    );

    always_comb begin
        st_d       = st_q;
        st_d.y1    = cell_r1;
        st_d.y0    = cell_r0;
        st_d.ack_a = ack_a_nx;
        st_d.ack_b = ack_b_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign y_r1  = st_q.y1;
    assign y_r0  = st_q.y0;
    assign a_ack = st_q.ack_a;
    assign b_ack = st_q.ack_b;
endmodule

// File: rtl/dr_and_stage_chk.sv
module dr_and_stage_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] a_r1,
    input logic [W-1:0] a_r0,
    input logic         a_ack,
    input logic [W-1:0] b_r1,
    input logic [W-1:0] b_r0,
    input logic         b_ack,
    input logic [W-1:0] y_r1,
    input logic [W-1:0] y_r0,
    input logic         y_ack
);
    // R1: no (1,1) code anywhere
    assert_no_bad_code_in_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((a_r1 & a_r0) == '0) && ((b_r1 & b_r0) == '0));
    assert_no_bad_code_out_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (y_r1 & y_r0) == '0);

    // R2: reset state
    always @(posedge clk)
        if (!rst_n)
            assert_reset_idle_R2: assert ((y_r1 | y_r0 | W'(a_ack) | W'(b_ack)) == '0 || 1'b1 == 1'b0 ? 1'b1 : $past(!rst_n) == 1'b0 || ((y_r1 | y_r0) == '0 && !a_ack && !b_ack));

    // R3: early zero fires
    assert_early_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (~$past(y_r1 | y_r0) & $past(a_r0 | b_r0) & {W{!$past(y_ack)}} & ~y_r0) == '0);

    // R4: a one needs both operands one
    assert_one_needs_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (y_r1 & ~$past(y_r1) & ~$past(a_r1 & b_r1)) == '0);

    // R6: valid bits hold until full drain
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (((($past(y_r1) ^ y_r1) | ($past(y_r0) ^ y_r0)) & $past(y_r1 | y_r0)) != '0)
        |-> ((y_r1 | y_r0) == '0));

    // R7: acknowledges rise only on a complete channel with y_ack high
    assert_ack_a_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(a_ack) |-> ($past(y_ack) && (&$past(a_r1 | a_r0))));
    assert_ack_b_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(b_ack) |-> ($past(y_ack) && (&$past(b_r1 | b_r0))));

    // R8: acknowledges fall only on an empty channel with y_ack low
    assert_ack_a_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(a_ack) |-> (!$past(y_ack) && ($past(a_r1 | a_r0) == '0)));

    // R9: drain only after both channels absorbed and emptied
    assert_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (((y_r1 | y_r0) == '0) && ($past(y_r1 | y_r0) != '0))
        |-> ($past(a_ack) && $past(b_ack) && $past(y_ack)
             && ($past(a_r1 | a_r0 | b_r1 | b_r0) == '0)));

    // R10: nothing fires while y_ack is high
    assert_no_fire_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(y_ack) |-> (((y_r1 | y_r0) & ~$past(y_r1 | y_r0)) == '0));
endmodule

bind dr_and_stage dr_and_stage_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .a_r1(a_r1), .a_r0(a_r0), .a_ack(a_ack),
    .b_r1(b_r1), .b_r0(b_r0), .b_ack(b_ack),
    .y_r1(y_r1), .y_r0(y_r0), .y_ack(y_ack)
);

// File: tb/tb_dr_and_stage.sv
module tb_dr_and_stage;
    localparam int W = 8;
    localparam int NV = 8;
    // {a, b, b_first, gap}
    localparam logic [19:0] VEC [0:NV-1] = '{
        {8'hA5, 8'h3C, 1'b1, 3'd2},
        {8'h00, 8'hFF, 1'b0, 3'd1},
        {8'hFF, 8'hFF, 1'b1, 3'd1},
        {8'h0F, 8'hF0, 1'b0, 3'd3},
        {8'h5A, 8'h00, 1'b1, 3'd2},
        {8'hC3, 8'h81, 1'b0, 3'd4},
        {8'hFF, 8'h01, 1'b1, 3'd1},
        {8'h77, 8'hEE, 1'b0, 3'd2}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] a_r1 = '0, a_r0 = '0, b_r1 = '0, b_r0 = '0;
    logic [W-1:0] y_r1, y_r0;
    logic a_ack, b_ack;
    logic y_ack = 1'b0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dr_and_stage #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n),
        .a_r1(a_r1), .a_r0(a_r0), .a_ack(a_ack),
        .b_r1(b_r1), .b_r0(b_r0), .b_ack(b_ack),
        .y_r1(y_r1), .y_r0(y_r0), .y_ack(y_ack)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        cyc(50000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        cyc(2);
        // R2: reset holds everything low
        check("R2 rails", {16'h0, y_r1, y_r0}, 32'h0);
        check("R2 acks", {30'h0, a_ack, b_ack}, 32'h0);
        rst_n = 1'b1;
        cyc(2);

        for (int v = 0; v < NV; v++) begin
            logic [W-1:0] va, vb, first, prod;
            logic bf;
            int gap;
            va = VEC[v][19:12];
            vb = VEC[v][11:4];
            bf = VEC[v][3];
            gap = int'(VEC[v][2:0]);
            first = bf ? vb : va;
            prod = va & vb;
            if (bf) begin b_r1 = vb; b_r0 = ~vb; end
            else    begin a_r1 = va; a_r0 = ~va; end
            cyc(gap);
            // R3/R4: only zeros of the first operand resolved early
            check("R3 early zero", {16'h0, y_r0}, {16'h0, ~first});
            check("R4 no early one", {16'h0, y_r1}, 32'h0);
            if (bf) begin a_r1 = va; a_r0 = ~va; end
            else    begin b_r1 = vb; b_r0 = ~vb; end
            cyc(1);
            check("R5 result", {16'h0, y_r1, y_r0}, {16'h0, prod, ~prod});
            y_ack = 1'b1;
            cyc(1);
            check("R7 acks rise", {30'h0, a_ack, b_ack}, 32'h3);
            a_r1 = '0; a_r0 = '0; b_r1 = '0; b_r0 = '0;
            cyc(1);
            check("R9 drain", {16'h0, y_r1, y_r0}, 32'h0);
            y_ack = 1'b0;
            cyc(1);
            check("R8 acks fall", {30'h0, a_ack, b_ack}, 32'h0);
        end

        // R9 and R7: late operand A held off after B is released
        b_r1 = '0; b_r0 = '1;
        cyc(1);
        check("R3 all zero early", {16'h0, y_r1, y_r0}, 32'h00FF);
        y_ack = 1'b1;
        cyc(1);
        check("R7 only b acked", {30'h0, a_ack, b_ack}, 32'h1);
        b_r0 = '0;
        cyc(3);
        check("R9 held for late a", {16'h0, y_r1, y_r0}, 32'h00FF);
        check("R7 a still waits", {31'h0, a_ack}, 32'h0);
        a_r1 = 8'hFF;
        cyc(1);
        check("R6 value kept", {16'h0, y_r1, y_r0}, 32'h00FF);
        check("R7 late a acked", {31'h0, a_ack}, 32'h1);
        cyc(1);
        check("R8 b ack held while y_ack high", {31'h0, b_ack}, 32'h1);
        a_r1 = '0;
        cyc(1);
        check("R9 drain after absorb", {16'h0, y_r1, y_r0}, 32'h0);
        y_ack = 1'b0;
        cyc(1);
        check("R8 both fall", {30'h0, a_ack, b_ack}, 32'h0);

        // R10: data offered while y_ack still high does not fire
        y_ack = 1'b1;
        a_r0 = '1; b_r1 = 8'h3C; b_r0 = 8'hC3;
        cyc(2);
        check("R10 no fire", {16'h0, y_r1, y_r0}, 32'h0);
        a_r0 = '0; b_r1 = '0; b_r0 = '0;
        y_ack = 1'b0;
        cyc(2);
        check("R8 idle again", {30'h0, a_ack, b_ack}, 32'h0);
        check("R1 output still NULL", {16'h0, y_r1, y_r0}, 32'h0);

        finish_run();
    end
endmodule